// File: doc/BRIEF.md
# Extended Low-Power State Sequencer

This block steers a processor package into and out of its idle levels. A request to go idle carries a level code and a hint asking for the extended form. In the extended form the block first asks the operating-point controller to move to the lowest point. It enables the idle state only after that transition reports completion. When a break event arrives, the block raises a one-cycle wake indication straight away, so software resumes at once. At the same time it asks for a transition back to the operating point that was in effect when the request was accepted.

The extended form applies in three cases: the request carries the hint, a configuration bit promotes every plain request, or the request is for the deepest level, which always uses the extended form. Otherwise the block enters the idle state directly and leaves the operating point alone. The block is busy from acceptance until the sequence is over. While it is busy, new requests are dropped.

Top module: `xlp_sequencer`

## Requirements
- R1: After reset `busy`, `idle_en`, `pt_req_valid` and `wake` are all 0.
- R2: An accepted extended request sets `pt_req_valid`=1 with `pt_req`=0 (the lowest point) and keeps `idle_en`=0 from the next cycle. The cycle after `xfer_done` is sampled, `pt_req_valid` falls, `idle_en` rises and `idle_lvl` shows the request's level code. `idle_en` and `pt_req_valid` are never high together.
- R3: A plain request (level code 1, 2, 3 or 4, hint 0, `cfg_promote`=0) sets `idle_en`=1 and `idle_lvl` to its code in the next cycle, and never raises `pt_req_valid`.
- R4: With `cfg_promote`=1, a plain request follows the extended sequence of R2.
- R5: Level code 6 (the deepest level) always follows the extended sequence, even with hint 0 and `cfg_promote`=0.
- R6: A break while idle after an extended entry drops `idle_en` and raises `wake` for exactly one cycle in the next cycle. In that same cycle it starts `pt_req_valid`=1 with `pt_req` equal to the `cur_point` sampled when the request was accepted.
- R7: A break while idle after a plain entry drops `idle_en`, pulses `wake` for one cycle and clears `busy` in the next cycle, with no operating-point request.
- R8: A break during the down-transition aborts entry. In the next cycle `wake` pulses and `pt_req` becomes the saved point. `idle_en` is never raised, and a break takes precedence over a simultaneous `xfer_done`.
- R9: `busy` is 1 from the cycle after acceptance until the cycle after `xfer_done` is sampled during the restore, when `busy` and `pt_req_valid` fall together.
- R10: A request made while `busy`=1 is ignored. It changes neither `idle_lvl` nor the restore target.
- R11: Requests with level codes 0, 5 or 7 are ignored, and `busy` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Idle-entry request strobe |
| req_level | input | 3 | Idle level code: 1,2,3,4,6 |
| req_ext_hint | input | 1 | Ask for the extended form |
| cfg_promote | input | 1 | Promote plain requests to extended |
| brk | input | 1 | Break (wake-up) event |
| cur_point | input | PW | Operating point in effect |
| xfer_done | input | 1 | Operating-point transition complete |
| pt_req_valid | output | 1 | Operating-point transition requested |
| pt_req | output | PW | Requested operating point |
| idle_en | output | 1 | Package idle state enabled |
| idle_lvl | output | 3 | Level code of the accepted request |
| wake | output | 1 | One-cycle return-to-software pulse |
| busy | output | 1 | Sequence in progress |

## Verification
The assertions assume that `xfer_done` is a response to an outstanding operating-point request. They also assume that `brk` and `xfer_done` are only meaningful while a sequence is running, and that `cur_point` holds a settled value when a request is accepted. The stimulus pulses `xfer_done` only while `pt_req_valid` is high. It presents `brk` only during the drop or idle phases, with one deliberate exception: one case asserts `brk` together with `xfer_done` to check that the break wins. All inputs change half a cycle away from the sampling edge.

// File: rtl/xlp_pkg.sv
package xlp_pkg;
  typedef enum logic [1:0] {
    ST_RUN     = 2'd0,
    ST_DROP    = 2'd1,
    ST_SLEEP   = 2'd2,
    ST_RESTORE = 2'd3
  } xlp_state_t;

  localparam logic [2:0] LVL_DEEPEST = 3'd6;

  function automatic logic lvl_supported(input logic [2:0] lvl);
    return (lvl >= 3'd1 && lvl <= 3'd4) || (lvl == LVL_DEEPEST);
  endfunction

  function automatic logic wants_extended(input logic [2:0] lvl,
                                          input logic hint,
                                          input logic promote);
    return hint || promote || (lvl == LVL_DEEPEST);
  endfunction
endpackage

// File: rtl/xlp_entry_decode.sv
module xlp_entry_decode
  import xlp_pkg::*;
(
  input  logic       req_valid,
  input  logic       busy,
  input  logic [2:0] req_level,
  input  logic       req_ext_hint,
  input  logic       cfg_promote,
  output logic       accept,
  output logic       accept_ext
);
  logic level_ok;

  assign level_ok   = lvl_supported(req_level);
  assign accept     = req_valid && !busy && level_ok;
  assign accept_ext = accept && wants_extended(req_level, req_ext_hint, cfg_promote);
endmodule

// File: rtl/xlp_point_store.sv
module xlp_point_store #(
  parameter int PW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          capture,
  input  logic [PW-1:0] cur_point,
  output logic [PW-1:0] saved_point
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       saved_point <= '0;
    else if (capture) saved_point <= cur_point;
  end

  assert_target_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !capture |=> $stable(saved_point));
endmodule

// File: rtl/xlp_fsm.sv
module xlp_fsm
  import xlp_pkg::*;
#(
  parameter int PW = 4,
  parameter logic [PW-1:0] MIN_POINT = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic          accept_ext,
  input  logic [2:0]    req_level,
  input  logic          brk,
  input  logic          xfer_done,
  input  logic [PW-1:0] saved_point,
  output logic          pt_req_valid,
  output logic [PW-1:0] pt_req,
  output logic          idle_en,
  output logic [2:0]    idle_lvl,
  output logic          wake,
  output logic          busy
);
  xlp_state_t state, state_nx;
  logic       ext_q;
  logic       brk_take;
  logic       drop_done;
  logic       restore_done;

  assign brk_take     = brk && (state == ST_DROP || state == ST_SLEEP);
  assign drop_done    = (state == ST_DROP) && xfer_done && !brk;
  assign restore_done = (state == ST_RESTORE) && xfer_done;

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_RUN:     if (accept) state_nx = accept_ext ? ST_DROP : ST_SLEEP;
      ST_DROP:    if (brk_take) state_nx = ST_RESTORE;
                  else if (drop_done) state_nx = ST_SLEEP;
      ST_SLEEP:   if (brk_take) state_nx = ext_q ? ST_RESTORE : ST_RUN;
      ST_RESTORE: if (restore_done) state_nx = ST_RUN;
      default:    state_nx = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_RUN;
      ext_q    <= 1'b0;
      idle_lvl <= '0;
      wake     <= 1'b0;
    end else begin
      state <= state_nx;
      wake  <= brk_take;
      if (accept) begin
        ext_q    <= accept_ext;
        idle_lvl <= req_level;
      end
    end
  end

  assign pt_req_valid = (state == ST_DROP) || (state == ST_RESTORE);
  assign pt_req       = (state == ST_DROP) ? MIN_POINT : saved_point;
  assign idle_en      = (state == ST_SLEEP);
  assign busy         = (state != ST_RUN);

  assert_no_overlap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(idle_en && pt_req_valid));
  assert_sleep_after_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(idle_en) && $past(pt_req_valid)) |-> $past(xfer_done && !brk));
  assert_wake_on_break_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_en && brk) |=> (wake && !idle_en));
  assert_wake_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wake |=> !wake);
  assert_abort_restore_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pt_req_valid && !idle_en && brk && pt_req == MIN_POINT && !wake) |=>
      (pt_req_valid && !idle_en && wake));
endmodule

// File: rtl/xlp_sequencer.sv
module xlp_sequencer
  import xlp_pkg::*;
#(
  parameter int PW = 4,
  parameter logic [PW-1:0] MIN_POINT = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [2:0]    req_level,
  input  logic          req_ext_hint,
  input  logic          cfg_promote,
  input  logic          brk,
  input  logic [PW-1:0] cur_point,
  input  logic          xfer_done,
  output logic          pt_req_valid,
  output logic [PW-1:0] pt_req,
  output logic          idle_en,
  output logic [2:0]    idle_lvl,
  output logic          wake,
  output logic          busy
);
  logic          accept;
  logic          accept_ext;
  logic [PW-1:0] saved_point;

  xlp_entry_decode u_decode (
    .req_valid   (req_valid),
    .busy        (busy),
    .req_level   (req_level),
    .req_ext_hint(req_ext_hint),
    .cfg_promote (cfg_promote),
    .accept      (accept),
    .accept_ext  (accept_ext)
  );

  xlp_point_store #(.PW(PW)) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .capture    (accept),
    .cur_point  (cur_point),
    .saved_point(saved_point)
  );

  xlp_fsm #(.PW(PW), .MIN_POINT(MIN_POINT)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .accept      (accept),
    .accept_ext  (accept_ext),
    .req_level   (req_level),
    .brk         (brk),
    .xfer_done   (xfer_done),
    .saved_point (saved_point),
    .pt_req_valid(pt_req_valid),
    .pt_req      (pt_req),
    .idle_en     (idle_en),
    .idle_lvl    (idle_lvl),
    .wake        (wake),
    .busy        (busy)
  );

  assert_deepest_extended_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !busy && req_level == LVL_DEEPEST) |=>
      (pt_req_valid && pt_req == MIN_POINT && !idle_en));
  assert_busy_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(xfer_done || brk));
  assert_bad_level_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !busy && (req_level == 3'd0 || req_level == 3'd5 || req_level == 3'd7))
      |=> !busy);
endmodule

// File: tb/xlp_sequencer_tb_top.sv
module xlp_sequencer_tb_top;
  localparam int PW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic [2:0]    req_level = 3'd0;
  logic          req_ext_hint = 1'b0;
  logic          cfg_promote = 1'b0;
  logic          brk = 1'b0;
  logic [PW-1:0] cur_point = '0;
  logic          xfer_done = 1'b0;
  logic          pt_req_valid;
  logic [PW-1:0] pt_req;
  logic          idle_en;
  logic [2:0]    idle_lvl;
  logic          wake;
  logic          busy;

  int tests = 0;
  int fails = 0;

  always #2 clk = ~clk;

  xlp_sequencer #(.PW(PW)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_level(req_level),
    .req_ext_hint(req_ext_hint), .cfg_promote(cfg_promote), .brk(brk),
    .cur_point(cur_point), .xfer_done(xfer_done), .pt_req_valid(pt_req_valid),
    .pt_req(pt_req), .idle_en(idle_en), .idle_lvl(idle_lvl), .wake(wake), .busy(busy)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_req(input logic [2:0] lvl, input logic hint, input logic prom,
                        input logic [PW-1:0] pt);
    req_valid = 1'b1; req_level = lvl; req_ext_hint = hint;
    cfg_promote = prom; cur_point = pt;
    tick();
    req_valid = 1'b0; req_ext_hint = 1'b0; cfg_promote = 1'b0;
    cur_point = 4'd1;
  endtask

  task automatic pulse_done();
    xfer_done = 1'b1; tick(); xfer_done = 1'b0;
  endtask

  task automatic pulse_brk();
    brk = 1'b1; tick(); brk = 1'b0;
  endtask

  task automatic run_ext(input string tag, input logic [2:0] lvl, input logic hint,
                         input logic prom, input logic [PW-1:0] pt);
    do_req(lvl, hint, prom, pt);
    chk({tag, " drop busy"}, busy, 1);
    chk({tag, " drop req"}, pt_req_valid, 1);
    chk({tag, " drop min"}, pt_req, 0);
    chk({tag, " drop no idle"}, idle_en, 0);
    tick(); tick();
    chk({tag, " drop holds"}, idle_en, 0);
    pulse_done();
    chk({tag, " idle on"}, idle_en, 1);
    chk({tag, " req off"}, pt_req_valid, 0);
    chk({tag, " level"}, idle_lvl, lvl);
    pulse_brk();
    chk({tag, " R6 wake"}, wake, 1);
    chk({tag, " R6 idle off"}, idle_en, 0);
    chk({tag, " R6 restore req"}, pt_req_valid, 1);
    chk({tag, " R6 restore tgt"}, pt_req, pt);
    tick();
    chk({tag, " R6 wake single"}, wake, 0);
    chk({tag, " R9 busy in restore"}, busy, 1);
    pulse_done();
    chk({tag, " R9 busy off"}, busy, 0);
    chk({tag, " R9 req off"}, pt_req_valid, 0);
  endtask

  task automatic t_reset();
    chk("R1 busy", busy, 0);
    chk("R1 idle_en", idle_en, 0);
    chk("R1 pt_req_valid", pt_req_valid, 0);
    chk("R1 wake", wake, 0);
  endtask

  task automatic t_plain();
    for (int l = 1; l <= 4; l++) begin
      do_req(l[2:0], 1'b0, 1'b0, 4'd9);
      chk("R3 idle on", idle_en, 1);
      chk("R3 no pt req", pt_req_valid, 0);
      chk("R3 level", idle_lvl, l);
      tick();
      chk("R3 still no pt req", pt_req_valid, 0);
      pulse_brk();
      chk("R7 wake", wake, 1);
      chk("R7 idle off", idle_en, 0);
      chk("R7 busy off", busy, 0);
      chk("R7 no pt req", pt_req_valid, 0);
      tick();
      chk("R7 wake single", wake, 0);
    end
  endtask

  task automatic t_brk_drop();
    do_req(3'd3, 1'b1, 1'b0, 4'd11);
    tick();
    brk = 1'b1; xfer_done = 1'b1;
    tick();
    brk = 1'b0; xfer_done = 1'b0;
    chk("R8 wake", wake, 1);
    chk("R8 no idle", idle_en, 0);
    chk("R8 restore req", pt_req_valid, 1);
    chk("R8 restore tgt", pt_req, 11);
    tick();
    chk("R8 still no idle", idle_en, 0);
    pulse_done();
    chk("R8 busy off", busy, 0);
  endtask

  task automatic t_ignore_busy();
    do_req(3'd2, 1'b1, 1'b0, 4'd5);
    pulse_done();
    chk("R10 idle on", idle_en, 1);
    do_req(3'd4, 1'b0, 1'b0, 4'd13);
    chk("R10 level kept", idle_lvl, 2);
    chk("R10 still idle", idle_en, 1);
    pulse_brk();
    chk("R10 target kept", pt_req, 5);
    pulse_done();
    chk("R10 done", busy, 0);
  endtask

  task automatic t_bad_level();
    int codes[3] = '{0, 5, 7};
    foreach (codes[i]) begin
      do_req(codes[i][2:0], 1'b1, 1'b1, 4'd7);
      chk("R11 busy stays low", busy, 0);
      chk("R11 no pt req", pt_req_valid, 0);
      chk("R11 no idle", idle_en, 0);
    end
  endtask

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    tick();
    t_reset();
    rst_n = 1'b1;
    tick();
    t_reset();
    run_ext("R2 hint", 3'd1, 1'b1, 1'b0, 4'd12);
    run_ext("R4 promote", 3'd4, 1'b0, 1'b1, 4'd6);
    run_ext("R5 deepest", 3'd6, 1'b0, 1'b0, 4'd15);
    t_plain();
    t_brk_drop();
    t_ignore_busy();
    t_bad_level();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule